// File: doc/BRIEF.md
# Byte-Masked Remote Mailbox Writer

This engine turns one 64-bit send command into a single 32-bit write to another core's address space. The command names the target core, a 32-bit payload and a four-bit keep mask. Each byte lane whose mask bit is set keeps the word already stored at the destination. Each lane whose bit is clear takes the matching payload byte. When any lane must be kept, the engine first reads the destination word over its master port, merges the bytes, and then writes the result back. When no lane is kept, it writes the payload straight away.

Commands arrive on two offsets of a 64-bit command window. The mailbox offset builds the destination from a fixed mailbox base and a slot selector in the command. The arbitrary offset takes a 16-bit destination straight from the command. The engine handles one command at a time and holds the command port off until the final write has been acknowledged. It then reports completion, or a decode error for a core that does not exist, with a one-cycle response pulse.

Top module: `mrw_top`

## Requirements
- R1: A command starts work only when cmd_full is high and cmd_offset equals MAIL_OFF (default 0x040) or ANY_OFF (default 0x0C0). Any other command is accepted and dropped: no master request, no response pulse, and cmd_ready stays high.
- R2: The target core is cmd_data[25:16]. A value of NUM_CORES (default 4) or above gives a one-cycle resp_valid with resp_err high in the cycle after acceptance, and issues no master request.
- R3: For the mailbox offset the destination is MBOX_BASE (default 0x1000) + 0x20 + (cmd_data & 0x1C), so bits 1:0 of the command have no effect on the address.
- R4: For the arbitrary offset the destination is cmd_data[15:0].
- R5: If cmd_data[30:27] is not zero, the engine reads the destination word of the same core and address, then writes the merged word. Mask bit cmd_data[27+i] keeps bits 8i+7:8i of the old word, and a clear bit takes the same bits of the payload cmd_data[63:32].
- R6: If cmd_data[30:27] is zero, no read is issued and the payload cmd_data[63:32] is written unchanged.
- R7: Every master request carries the target core on mreq_core. mreq_write is 1 for a write and 0 for a read, and byte i of the word is bits 8i+7:8i.
- R8: cmd_ready is low from the cycle after acceptance until resp_valid has been shown. Success is one resp_valid cycle with resp_err low, in the cycle after the write's mrsp_valid.
- R9: While mreq_valid is high and mreq_ready is low, the request (valid, write, core, address and data) is held unchanged.
- R10: After reset cmd_ready is high and mreq_valid and resp_valid are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command present |
| cmd_ready | output | 1 | Engine idle, command taken on this edge |
| cmd_offset | input | OFF_W | Offset of the command within the 64-bit window |
| cmd_full | input | 1 | Command is a full 64-bit write |
| cmd_data | input | 64 | Send command word |
| resp_valid | output | 1 | One-cycle completion pulse |
| resp_err | output | 1 | Completion was a decode error |
| mreq_valid | output | 1 | Master request valid |
| mreq_ready | input | 1 | Master request taken |
| mreq_write | output | 1 | 1 for a write, 0 for a read |
| mreq_core | output | 10 | Core identity the access is made for |
| mreq_addr | output | 16 | Destination word address |
| mreq_wdata | output | 32 | Write data, little-endian lanes |
| mrsp_valid | input | 1 | Master response for the request in flight |
| mrsp_rdata | input | 32 | Read data of the response |

## Verification
The bench runs mask patterns that keep no lane, a single lane, alternating lanes and all lanes. A lane-order mistake or a swapped keep sense would then write the wrong bytes, and an all-ones mask must write back the old word exactly. It counts reads, so a design that reads for a zero mask, or writes without reading first, shows up in the count. Mailbox commands carry junk in bits 1:0, and the arbitrary offset carries stray bits 26 and 31, so a loose address or core decode lands on the wrong word. Commands for an unknown core, half-width commands and commands to unmapped offsets must produce no master traffic, and a stalled master port must not tear the request.

// File: rtl/mrw_pkg.sv
package mrw_pkg;

    localparam int CMD_W       = 64;
    localparam int WORD_W      = 32;
    localparam int ADDR_W      = 16;
    localparam int CORE_ID_W   = 10;
    localparam int LANES       = WORD_W / 8;

    // Field positions inside the send command
    localparam int CORE_LSB    = 16;
    localparam int KEEP_LSB    = 27;
    localparam int PAYLOAD_LSB = 32;

    // Mailbox slot addressing
    localparam logic [ADDR_W-1:0] MAIL_BIAS = 16'h0020;
    localparam logic [ADDR_W-1:0] MAIL_SEL  = 16'h001C;

    typedef logic [WORD_W-1:0]    word_t;
    typedef logic [ADDR_W-1:0]    addr_t;
    typedef logic [CORE_ID_W-1:0] core_t;
    typedef logic [LANES-1:0]     keep_t;

    typedef enum logic [1:0] {
        KIND_NONE,
        KIND_MAIL,
        KIND_ANY
    } kind_t;

    typedef struct packed {
        core_t core;
        addr_t addr;
        keep_t keep;
        word_t payload;
    } job_t;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RD_REQ,
        ST_RD_WAIT,
        ST_WR_REQ,
        ST_WR_WAIT,
        ST_RESP
    } state_t;

endpackage

// File: rtl/mrw_cmd_decode.sv
module mrw_cmd_decode
    import mrw_pkg::*;
#(
    parameter int                OFF_W     = 12,
    parameter logic [OFF_W-1:0]  MAIL_OFF  = 12'h040,
    parameter logic [OFF_W-1:0]  ANY_OFF   = 12'h0C0,
    parameter logic [ADDR_W-1:0] MBOX_BASE = 16'h1000,
    parameter int                NUM_CORES = 4
) (
    input  logic [OFF_W-1:0] cmd_offset,
    input  logic             cmd_full,
    input  logic [CMD_W-1:0] cmd_data,
    output kind_t            kind,
    output logic             known,
    output job_t             job
);

    localparam logic [CORE_ID_W:0] CORE_LIMIT = (CORE_ID_W+1)'(NUM_CORES);

    addr_t mail_addr;
    logic  unused_cmd_bits;

    assign unused_cmd_bits = ^{cmd_data[31], cmd_data[26]};

    always_comb begin
        if (!cmd_full)
            kind = KIND_NONE;
        else if (cmd_offset == MAIL_OFF)
            kind = KIND_MAIL;
        else if (cmd_offset == ANY_OFF)
            kind = KIND_ANY;
        else
            kind = KIND_NONE;
    end

    assign mail_addr   = MBOX_BASE + MAIL_BIAS + (cmd_data[ADDR_W-1:0] & MAIL_SEL);

    assign job.core    = cmd_data[CORE_LSB +: CORE_ID_W];
    assign job.keep    = cmd_data[KEEP_LSB +: LANES];
    assign job.payload = cmd_data[PAYLOAD_LSB +: WORD_W];
    assign job.addr    = (kind == KIND_MAIL) ? mail_addr : cmd_data[ADDR_W-1:0];

    assign known = {1'b0, job.core} < CORE_LIMIT;

    // R3: a mailbox destination stays word aligned inside the slot window
    always_comb begin
        if (kind == KIND_MAIL) begin
            assert_mail_window_R3: assert (job.addr[1:0] == 2'b00 &&
                                           job.addr >= MBOX_BASE + MAIL_BIAS &&
                                           job.addr <= MBOX_BASE + MAIL_BIAS + MAIL_SEL);
        end
    end

endmodule

// File: rtl/mrw_byte_merge.sv
module mrw_byte_merge
    import mrw_pkg::*;
(
    input  word_t prior,
    input  word_t fresh,
    input  keep_t keep,
    output word_t merged
);

    for (genvar lane = 0; lane < LANES; lane++) begin : g_lane
        assign merged[lane*8 +: 8] = keep[lane] ? prior[lane*8 +: 8] : fresh[lane*8 +: 8];
    end

    // R6: with nothing kept the payload passes untouched
    always_comb begin
        if (keep == '0) begin
            assert_no_keep_passthru_R6: assert (merged == fresh);
        end
    end

endmodule

// File: rtl/mrw_sequencer.sv
module mrw_sequencer
    import mrw_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  cmd_valid,
    output logic  cmd_ready,
    input  kind_t cmd_kind,
    input  logic  cmd_known,
    input  job_t  cmd_job,
    output logic  resp_valid,
    output logic  resp_err,
    output logic  mreq_valid,
    input  logic  mreq_ready,
    output logic  mreq_write,
    output core_t mreq_core,
    output addr_t mreq_addr,
    output word_t mreq_wdata,
    input  logic  mrsp_valid,
    input  word_t mrsp_rdata
);

    state_t state_q, state_d;
    job_t   job_q;
    word_t  wdata_q;
    word_t  merged;
    logic   err_q;
    logic   accept;
    logic   start;

    mrw_byte_merge u_merge (
        .prior  (mrsp_rdata),
        .fresh  (job_q.payload),
        .keep   (job_q.keep),
        .merged (merged)
    );

    assign accept = cmd_valid && cmd_ready;
    assign start  = accept && (cmd_kind != KIND_NONE);

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (start) begin
                    if (!cmd_known)
                        state_d = ST_RESP;
                    else if (cmd_job.keep != '0)
                        state_d = ST_RD_REQ;
                    else
                        state_d = ST_WR_REQ;
                end
            end
            ST_RD_REQ:  if (mreq_ready) state_d = ST_RD_WAIT;
            ST_RD_WAIT: if (mrsp_valid) state_d = ST_WR_REQ;
            ST_WR_REQ:  if (mreq_ready) state_d = ST_WR_WAIT;
            ST_WR_WAIT: if (mrsp_valid) state_d = ST_RESP;
            ST_RESP:    state_d = ST_IDLE;
            default:    state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            job_q   <= '0;
            wdata_q <= '0;
            err_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            if (start) begin
                job_q   <= cmd_job;
                wdata_q <= cmd_job.payload;
                err_q   <= !cmd_known;
            end
            if (state_q == ST_RD_WAIT && mrsp_valid)
                wdata_q <= merged;
        end
    end

    assign cmd_ready  = (state_q == ST_IDLE);
    assign mreq_valid = (state_q == ST_RD_REQ) || (state_q == ST_WR_REQ);
    assign mreq_write = (state_q == ST_WR_REQ);
    assign mreq_core  = job_q.core;
    assign mreq_addr  = job_q.addr;
    assign mreq_wdata = wdata_q;
    assign resp_valid = (state_q == ST_RESP);
    assign resp_err   = err_q;

    // R1: dropped commands leave the engine idle and silent
    assert_drop_silent_R1: assert property (@(posedge clk) disable iff (rst)
        (accept && cmd_kind == KIND_NONE) |=> (cmd_ready && !mreq_valid && !resp_valid));

    // R2: an unknown core answers with an error at once and touches no target
    assert_unknown_core_R2: assert property (@(posedge clk) disable iff (rst)
        (start && !cmd_known) |=> (resp_valid && resp_err && !mreq_valid));

    // R5: a merged write only follows a returned read
    assert_read_before_merge_R5: assert property (@(posedge clk) disable iff (rst)
        ($rose(mreq_valid) && mreq_write && job_q.keep != '0) |-> $past(mrsp_valid));

    // R8: success is reported only right after a response came back
    assert_done_after_ack_R8: assert property (@(posedge clk) disable iff (rst)
        (resp_valid && !resp_err) |-> $past(mrsp_valid));

    // R8: the command port is closed while the master port is active
    assert_busy_backpressure_R8: assert property (@(posedge clk) disable iff (rst)
        mreq_valid |-> !cmd_ready);

    // R9: a stalled request is held unchanged
    assert_req_stable_R9: assert property (@(posedge clk) disable iff (rst)
        (mreq_valid && !mreq_ready) |=> (mreq_valid && $stable(mreq_write) &&
            $stable(mreq_addr) && $stable(mreq_core) && $stable(mreq_wdata)));

endmodule

// File: rtl/mrw_top.sv
module mrw_top
    import mrw_pkg::*;
#(
    parameter int                OFF_W     = 12,
    parameter logic [OFF_W-1:0]  MAIL_OFF  = 12'h040,
    parameter logic [OFF_W-1:0]  ANY_OFF   = 12'h0C0,
    parameter logic [ADDR_W-1:0] MBOX_BASE = 16'h1000,
    parameter int                NUM_CORES = 4
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 cmd_valid,
    output logic                 cmd_ready,
    input  logic [OFF_W-1:0]     cmd_offset,
    input  logic                 cmd_full,
    input  logic [CMD_W-1:0]     cmd_data,
    output logic                 resp_valid,
    output logic                 resp_err,
    output logic                 mreq_valid,
    input  logic                 mreq_ready,
    output logic                 mreq_write,
    output logic [CORE_ID_W-1:0] mreq_core,
    output logic [ADDR_W-1:0]    mreq_addr,
    output logic [WORD_W-1:0]    mreq_wdata,
    input  logic                 mrsp_valid,
    input  logic [WORD_W-1:0]    mrsp_rdata
);

    kind_t dec_kind;
    logic  dec_known;
    job_t  dec_job;

    mrw_cmd_decode #(
        .OFF_W     (OFF_W),
        .MAIL_OFF  (MAIL_OFF),
        .ANY_OFF   (ANY_OFF),
        .MBOX_BASE (MBOX_BASE),
        .NUM_CORES (NUM_CORES)
    ) u_decode (
        .cmd_offset (cmd_offset),
        .cmd_full   (cmd_full),
        .cmd_data   (cmd_data),
        .kind       (dec_kind),
        .known      (dec_known),
        .job        (dec_job)
    );

    mrw_sequencer u_seq (
        .clk        (clk),
        .rst        (rst),
        .cmd_valid  (cmd_valid),
        .cmd_ready  (cmd_ready),
        .cmd_kind   (dec_kind),
        .cmd_known  (dec_known),
        .cmd_job    (dec_job),
        .resp_valid (resp_valid),
        .resp_err   (resp_err),
        .mreq_valid (mreq_valid),
        .mreq_ready (mreq_ready),
        .mreq_write (mreq_write),
        .mreq_core  (mreq_core),
        .mreq_addr  (mreq_addr),
        .mreq_wdata (mreq_wdata),
        .mrsp_valid (mrsp_valid),
        .mrsp_rdata (mrsp_rdata)
    );

    // R10: leaving reset the engine is idle
    assert_reset_idle_R10: assert property (@(posedge clk)
        $past(rst) |-> (cmd_ready && !mreq_valid && !resp_valid));

endmodule

// File: tb/mrw_top_tb_top.sv
`timescale 1ns/100ps
module mrw_top_tb_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cmd_valid = 1'b0;
    logic        cmd_ready;
    logic [11:0] cmd_offset = '0;
    logic        cmd_full = 1'b0;
    logic [63:0] cmd_data = '0;
    logic        resp_valid;
    logic        resp_err;
    logic        mreq_valid;
    logic        mreq_ready = 1'b1;
    logic        mreq_write;
    logic [9:0]  mreq_core;
    logic [15:0] mreq_addr;
    logic [31:0] mreq_wdata;
    logic        mrsp_valid = 1'b0;
    logic [31:0] mrsp_rdata = '0;

    always #2.5 clk = ~clk;

    mrw_top dut_i (
        .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
        .cmd_offset(cmd_offset), .cmd_full(cmd_full), .cmd_data(cmd_data),
        .resp_valid(resp_valid), .resp_err(resp_err),
        .mreq_valid(mreq_valid), .mreq_ready(mreq_ready), .mreq_write(mreq_write),
        .mreq_core(mreq_core), .mreq_addr(mreq_addr), .mreq_wdata(mreq_wdata),
        .mrsp_valid(mrsp_valid), .mrsp_rdata(mrsp_rdata)
    );

    int n_checks = 0;
    int n_fail   = 0;

    task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Target model: memory keyed by core*65536+addr, one-cycle response
    logic [31:0] mem [int];
    int          hold = 0;
    int          n_rd = 0;
    int          n_wr = 0;
    logic [9:0]  rd_core, wr_core;
    logic [15:0] rd_addr, wr_addr;
    logic [31:0] wr_data;
    bit          pend = 0;
    logic [31:0] pdata = '0;

    initial begin
        forever begin
            @(negedge clk);
            mrsp_valid = 1'b0;
            if (pend) begin
                mrsp_valid = 1'b1;
                mrsp_rdata = pdata;
                pend = 0;
            end else if (mreq_valid) begin
                if (hold > 0) begin
                    mreq_ready = 1'b0;
                    hold--;
                end else begin
                    int key;
                    mreq_ready = 1'b1;
                    key = int'(mreq_core) * 65536 + int'(mreq_addr);
                    if (mreq_write) begin
                        n_wr++;
                        wr_core = mreq_core;
                        wr_addr = mreq_addr;
                        wr_data = mreq_wdata;
                        mem[key] = mreq_wdata;
                        pdata = '0;
                    end else begin
                        n_rd++;
                        rd_core = mreq_core;
                        rd_addr = mreq_addr;
                        pdata = mem.exists(key) ? mem[key] : 32'h0;
                    end
                    pend = 1;
                end
            end else begin
                mreq_ready = 1'b1;
            end
        end
    end

    task automatic run_cmd(input logic [11:0] off, input logic full, input logic [63:0] data,
                           output bit got, output bit err, output bit busy);
        @(negedge clk);
        cmd_valid  = 1'b1;
        cmd_offset = off;
        cmd_full   = full;
        cmd_data   = data;
        while (!cmd_ready) @(negedge clk);
        @(negedge clk);
        cmd_valid = 1'b0;
        busy = !cmd_ready;
        got = 0;
        err = 0;
        for (int i = 0; i < 30; i++) begin
            if (resp_valid) begin
                got = 1;
                err = resp_err;
                break;
            end
            @(negedge clk);
        end
    endtask

    typedef struct packed {
        logic [11:0] off;
        logic [63:0] cmd;
        logic [31:0] old;
        logic        rd;
        logic [1:0]  core;
        logic [15:0] addr;
        logic [31:0] exp;
    } vec_t;

    localparam int NV = 6;
    localparam vec_t VECS [NV] = '{
        '{12'h040, 64'hDEADBEEF_00010008, 32'h00000000, 1'b0, 2'd1, 16'h1028, 32'hDEADBEEF},
        '{12'h040, 64'h11223344_2802001F, 32'hAABBCCDD, 1'b1, 2'd2, 16'h103C, 32'h11BB33DD},
        '{12'h0C0, 64'hFFFFFFFF_78000ABC, 32'h01234567, 1'b1, 2'd0, 16'h0ABC, 32'h01234567},
        '{12'h0C0, 64'hCAFEF00D_40035554, 32'h99887766, 1'b1, 2'd3, 16'h5554, 32'h99FEF00D},
        '{12'h0C0, 64'h0BADCAFE_84031234, 32'h5A5A5A5A, 1'b0, 2'd3, 16'h1234, 32'h0BADCAFE},
        '{12'h040, 64'h55667788_10000014, 32'hA1B2C3D4, 1'b1, 2'd0, 16'h1034, 32'h5566C388}
    };

    task automatic run_vec(input vec_t v, input string tag);
        bit got, err, busy;
        int r0, w0;
        mem[int'(v.core) * 65536 + int'(v.addr)] = v.old;
        r0 = n_rd;
        w0 = n_wr;
        run_cmd(v.off, 1'b1, v.cmd, got, err, busy);
        check(got && !err, {tag, " R8 completion"}, {62'd0, got, err}, 64'd2);
        check(busy, {tag, " R8 busy"}, 64'(busy), 64'd1);
        check(n_rd - r0 == int'(v.rd), {tag, " R5/R6 read count"}, 64'(n_rd - r0), 64'(v.rd));
        check(n_wr - w0 == 1, {tag, " R7 write count"}, 64'(n_wr - w0), 64'd1);
        check(wr_addr == v.addr, {tag, " R3/R4 address"}, 64'(wr_addr), 64'(v.addr));
        check(wr_core == 10'(v.core), {tag, " R7 core"}, 64'(wr_core), 64'(v.core));
        check(wr_data == v.exp, {tag, " R5/R6 data"}, 64'(wr_data), 64'(v.exp));
        if (v.rd) begin
            check(rd_addr == v.addr && rd_core == 10'(v.core), {tag, " R5 read target"},
                  {38'd0, rd_core, rd_addr}, {38'd0, 8'd0, v.core, v.addr});
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        bit got, err, busy;
        int r0, w0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R10 reset state
        check(cmd_ready && !mreq_valid && !resp_valid, "R10 reset idle",
              {61'd0, cmd_ready, mreq_valid, resp_valid}, 64'h4);

        for (int i = 0; i < NV; i++) begin
            run_vec(VECS[i], $sformatf("vec%0d", i));
        end

        // R9: stalled master port, masked command
        hold = 3;
        run_vec('{12'h040, 64'h11223344_2802001F, 32'h0F0E0D0C, 1'b1, 2'd2, 16'h103C, 32'h110E330C},
                "stall R9");

        // R2: unknown cores
        r0 = n_rd; w0 = n_wr;
        run_cmd(12'h040, 1'b1, 64'h12345678_00040000, got, err, busy);
        check(got && err, "R2 core 4 error", {62'd0, got, err}, 64'd3);
        check(n_rd == r0 && n_wr == w0, "R2 core 4 no traffic", 64'(n_rd + n_wr - r0 - w0), 64'd0);
        run_cmd(12'h0C0, 1'b1, 64'h12345678_7BFF0100, got, err, busy);
        check(got && err, "R2 core 1023 error", {62'd0, got, err}, 64'd3);
        check(n_rd == r0 && n_wr == w0, "R2 core 1023 no traffic", 64'(n_rd + n_wr - r0 - w0), 64'd0);

        // R1: half-width command at the mailbox offset is dropped
        run_cmd(12'h040, 1'b0, 64'h12345678_00010000, got, err, busy);
        check(!got, "R1 half-width no response", 64'(got), 64'd0);
        check(!busy && cmd_ready, "R1 half-width stays idle", 64'(busy), 64'd0);
        check(n_rd == r0 && n_wr == w0, "R1 half-width no traffic", 64'(n_rd + n_wr - r0 - w0), 64'd0);

        // R1: unmapped offset is dropped
        run_cmd(12'h080, 1'b1, 64'h12345678_00010000, got, err, busy);
        check(!got, "R1 other offset no response", 64'(got), 64'd0);
        check(n_rd == r0 && n_wr == w0, "R1 other offset no traffic", 64'(n_rd + n_wr - r0 - w0), 64'd0);

        // R8: engine recovers after an error and runs a new command
        run_vec(VECS[0], "after-error R8");

        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule